// File: doc/BRIEF.md
# Register-File ALU with Three-Way Compare Flags

This block pairs a combinational arithmetic/logic circuit with an eight-entry, sixteen-bit register bank. Each cycle a caller names an operation, two source registers and a destination. The circuit reads both sources over a shared path and shows the result on `result_o` in the same cycle. When `exec_i` is high, the result is written into the destination register at the next rising clock edge. A separate load port places constants into the bank, and a third read port lets the caller observe any register.

Compare works differently from the other operations. It writes no register. Instead it moves a small condition-code state machine into one of three states: greater, equal or less. The state is derived from an unsigned comparison of the two sources. The state machine has four states: `CC_CLEAR`, `CC_GT`, `CC_EQ` and `CC_LT`. Reset enters `CC_CLEAR`. From any state, an issued compare takes the `cmp_gt`, `cmp_eq` or `cmp_lt` transition to the matching state. Every other cycle takes the `hold` transition back into the same state. Each state drives exactly one flag, except `CC_CLEAR`, which drives none.

Multiply and divide are single-cycle combinational operations. Reset is synchronous and active high.

Top module: `alu_cc_unit`

## Requirements
- R1: A cycle with `rst` high at a rising edge clears every register to 0 and returns the flags to all-low.
- R2: When `load_en_i` is high at a rising edge, `load_data_i` is written into register `load_idx_i`. The new value then appears on `rd_data_o` when `rd_idx_i` selects that register.
- R3: Opcodes are 0 ADD, 1 SUB, 2 MUL, 3 DIV, 4 AND, 5 OR, 6 NOT and 7 CMP. ADD and SUB compute A+B and A−B modulo 2^16, where A and B are the registers named by `src_a_i` and `src_b_i`.
- R4: MUL gives the low 16 bits of the unsigned product A×B. DIV gives the unsigned quotient A/B.
- R5: DIV with B equal to 0 gives 0xFFFF, and the flags do not change.
- R6: AND and OR are bitwise on A and B. NOT inverts A and ignores B.
- R7: With `exec_i` high and no load, a non-compare result is written into register `dst_i` at the rising edge. With `exec_i` low, no register changes.
- R8: An issued CMP sets exactly one flag from an unsigned comparison: GT when A>B, EQ when A=B, LT when A<B.
- R9: An issued CMP writes no register, and `result_o` reads 0 during it.
- R10: The flags keep their value through every cycle that does not issue a CMP.
- R11: When `load_en_i` and `exec_i` are both high, the load owns the single write port and the ALU result is discarded.
- R12: When the destination is also a source, the operation uses the register's value from before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation select (encoding in R3) |
| src_a_i | input | 3 | Index of operand A register |
| src_b_i | input | 3 | Index of operand B register |
| dst_i | input | 3 | Index of destination register |
| exec_i | input | 1 | Issue the operation this cycle |
| load_en_i | input | 1 | Write `load_data_i` through the load port |
| load_idx_i | input | 3 | Register index for the load port |
| load_data_i | input | 16 | Value for the load port |
| rd_idx_i | input | 3 | Register index for the observation port |
| result_o | output | 16 | Combinational ALU result |
| flag_gt_o | output | 1 | Last compare found A > B |
| flag_eq_o | output | 1 | Last compare found A = B |
| flag_lt_o | output | 1 | Last compare found A < B |
| rd_data_o | output | 16 | Contents of register `rd_idx_i` |

## Verification
The assertions cover the flag behaviour on every cycle. After each compare exactly one flag is set, and the equal flag follows operand equality. Outside compares the flags hold, including across divides. Any register write lands with the value presented to the port, and the register bank holds its contents in cycles with no write.

Only the directed scenarios can show the arithmetic values. These cover wraparound in add and subtract, product truncation, the all-ones quotient on a zero divisor, and unsigned ordering on values with the top bit set. The scenarios also show load priority over the ALU result, destination-equals-source behaviour, and the clearing effect of reset.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;

    parameter int DATA_W   = 16;
    parameter int NUM_REGS = 8;
    localparam int IDX_W   = $clog2(NUM_REGS);
    localparam int OP_W    = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_MUL = 3'd2,
        OP_DIV = 3'd3,
        OP_AND = 3'd4,
        OP_OR  = 3'd5,
        OP_NOT = 3'd6,
        OP_CMP = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        CC_CLEAR = 2'd0,
        CC_GT    = 2'd1,
        CC_EQ    = 2'd2,
        CC_LT    = 2'd3
    } cc_state_e;

endpackage

// File: rtl/alu_cc_regfile.sv
module alu_cc_regfile
    import alu_cc_pkg::*;
#(
    parameter int W     = DATA_W,
    parameter int NREG  = NUM_REGS,
    localparam int IW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [IW-1:0] ra_a,
    input  logic [IW-1:0] ra_b,
    input  logic [IW-1:0] ra_c,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    output logic [W-1:0]  rd_c
);

    logic [NREG-1:0][W-1:0] mem;
    logic [NREG-1:0]        wsel;

    // one write-select line per register
    for (genvar g = 0; g < NREG; g++) begin : g_wsel
        assign wsel[g] = we && (wa == IW'(g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (wsel[i]) begin
                    mem[i] <= wd;
                end
            end
        end
    end

    assign rd_a = mem[ra_a];
    assign rd_b = mem[ra_b];
    assign rd_c = mem[ra_c];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        we |=> (mem[$past(wa)] == $past(wd)))
        else $error("register write did not land"); // R7

    AST_BANK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(mem))
        else $error("register bank changed without a write"); // R9

endmodule

// File: rtl/alu_cc_datapath.sv
module alu_cc_datapath
    import alu_cc_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         is_cmp,
    output logic         a_gt_b,
    output logic         a_eq_b,
    output logic         a_lt_b
);

    logic [W-1:0] quot;

    always_comb begin
        quot = '1;
        if (b != '0) begin
            quot = a / b;
        end
    end

    always_comb begin
        res    = '0;
        is_cmp = 1'b0;
        unique case (op)
            OP_ADD: res = a + b;
            OP_SUB: res = a - b;
            OP_MUL: res = a * b;
            OP_DIV: res = quot;
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_NOT: res = ~a;
            OP_CMP: is_cmp = 1'b1;
            default: res = '0;
        endcase
    end

    assign a_gt_b = (a > b);
    assign a_eq_b = (a == b);
    assign a_lt_b = (a < b);

endmodule

// File: rtl/alu_cc_ccr.sv
module alu_cc_ccr
    import alu_cc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic upd,
    input  logic a_gt_b,
    input  logic a_eq_b,
    input  logic a_lt_b,
    output logic flag_gt,
    output logic flag_eq,
    output logic flag_lt
);

    cc_state_e state_q;
    cc_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CC_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: cmp_gt / cmp_eq / cmp_lt on an issued compare, hold otherwise
    always_comb begin
        state_d = state_q;
        if (upd) begin
            if (a_eq_b) begin
                state_d = CC_EQ;
            end else if (a_gt_b) begin
                state_d = CC_GT;
            end else if (a_lt_b) begin
                state_d = CC_LT;
            end
        end
    end

    // outputs
    always_comb begin
        flag_gt = 1'b0;
        flag_eq = 1'b0;
        flag_lt = 1'b0;
        unique case (state_q)
            CC_CLEAR: ;
            CC_GT:    flag_gt = 1'b1;
            CC_EQ:    flag_eq = 1'b1;
            CC_LT:    flag_lt = 1'b1;
            default:  ;
        endcase
    end

    AST_CC_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        upd |=> ($countones({flag_gt, flag_eq, flag_lt}) == 1))
        else $error("compare did not leave exactly one flag"); // R8

    AST_CC_EQ_TRACK: assert property (@(posedge clk) disable iff (rst)
        (upd && a_eq_b) |=> flag_eq)
        else $error("equal operands did not raise EQ"); // R8

    AST_CC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable({flag_gt, flag_eq, flag_lt}))
        else $error("flags moved without a compare"); // R10

endmodule

// File: rtl/alu_cc_unit.sv
module alu_cc_unit
    import alu_cc_pkg::*;
#(
    parameter int W     = DATA_W,
    parameter int NREG  = NUM_REGS,
    localparam int IW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    op_i,
    input  logic [IW-1:0] src_a_i,
    input  logic [IW-1:0] src_b_i,
    input  logic [IW-1:0] dst_i,
    input  logic          exec_i,
    input  logic          load_en_i,
    input  logic [IW-1:0] load_idx_i,
    input  logic [W-1:0]  load_data_i,
    input  logic [IW-1:0] rd_idx_i,
    output logic [W-1:0]  result_o,
    output logic          flag_gt_o,
    output logic          flag_eq_o,
    output logic          flag_lt_o,
    output logic [W-1:0]  rd_data_o
);

    alu_op_e       op;
    logic [W-1:0]  opnd_a;
    logic [W-1:0]  opnd_b;
    logic [W-1:0]  alu_res;
    logic          is_cmp;
    logic          cmp_gt;
    logic          cmp_eq;
    logic          cmp_lt;
    logic          cc_upd;
    logic          rf_we;
    logic [IW-1:0] rf_wa;
    logic [W-1:0]  rf_wd;

    assign op = alu_op_e'(op_i);

    alu_cc_regfile #(.W(W), .NREG(NREG)) u_rf (
        .clk  (clk),
        .rst  (rst),
        .we   (rf_we),
        .wa   (rf_wa),
        .wd   (rf_wd),
        .ra_a (src_a_i),
        .ra_b (src_b_i),
        .ra_c (rd_idx_i),
        .rd_a (opnd_a),
        .rd_b (opnd_b),
        .rd_c (rd_data_o)
    );

    alu_cc_datapath #(.W(W)) u_dp (
        .op     (op),
        .a      (opnd_a),
        .b      (opnd_b),
        .res    (alu_res),
        .is_cmp (is_cmp),
        .a_gt_b (cmp_gt),
        .a_eq_b (cmp_eq),
        .a_lt_b (cmp_lt)
    );

    // single write port: load has priority over the ALU result
    always_comb begin
        rf_we = 1'b0;
        rf_wa = dst_i;
        rf_wd = alu_res;
        if (load_en_i) begin
            rf_we = 1'b1;
            rf_wa = load_idx_i;
            rf_wd = load_data_i;
        end else if (exec_i && !is_cmp) begin
            rf_we = 1'b1;
        end
    end

    assign cc_upd   = exec_i && is_cmp;
    assign result_o = alu_res;

    alu_cc_ccr u_ccr (
        .clk     (clk),
        .rst     (rst),
        .upd     (cc_upd),
        .a_gt_b  (cmp_gt),
        .a_eq_b  (cmp_eq),
        .a_lt_b  (cmp_lt),
        .flag_gt (flag_gt_o),
        .flag_eq (flag_eq_o),
        .flag_lt (flag_lt_o)
    );

    AST_DIV_FLAGS_KEEP: assert property (@(posedge clk) disable iff (rst)
        (exec_i && op_i == 3'd3) |=> $stable({flag_gt_o, flag_eq_o, flag_lt_o}))
        else $error("divide disturbed the flags"); // R5

endmodule

// File: tb/alu_cc_unit_bench.sv
module alu_cc_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op_i = '0;
    logic [2:0]  src_a_i = '0;
    logic [2:0]  src_b_i = '0;
    logic [2:0]  dst_i = '0;
    logic        exec_i = 1'b0;
    logic        load_en_i = 1'b0;
    logic [2:0]  load_idx_i = '0;
    logic [15:0] load_data_i = '0;
    logic [2:0]  rd_idx_i = '0;
    logic [15:0] result_o;
    logic        flag_gt_o, flag_eq_o, flag_lt_o;
    logic [15:0] rd_data_o;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;
    logic [15:0] m [8];
    logic [2:0]  ef;

    always #2 clk = ~clk;

    alu_cc_unit u_alu_cc_unit (
        .clk(clk), .rst(rst), .op_i(op_i), .src_a_i(src_a_i), .src_b_i(src_b_i),
        .dst_i(dst_i), .exec_i(exec_i), .load_en_i(load_en_i), .load_idx_i(load_idx_i),
        .load_data_i(load_data_i), .rd_idx_i(rd_idx_i), .result_o(result_o),
        .flag_gt_o(flag_gt_o), .flag_eq_o(flag_eq_o), .flag_lt_o(flag_lt_o),
        .rd_data_o(rd_data_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_op(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b);
        case (op)
            3'd0: return a + b;
            3'd1: return a - b;
            3'd2: return 16'((32'(a) * 32'(b)) & 32'h0000_FFFF);
            3'd3: return (b == 16'd0) ? 16'hFFFF : a / b;
            3'd4: return a & b;
            3'd5: return a | b;
            3'd6: return ~a;
            default: return 16'd0;
        endcase
    endfunction

    task automatic check_bank(input string req);
        for (int i = 0; i < 8; i++) begin
            rd_idx_i = 3'(i);
            #1;
            chk(req, rd_data_o, m[i]);
        end
    endtask

    task automatic check_flags(input string req);
        chk(req, {13'd0, flag_gt_o, flag_eq_o, flag_lt_o}, {13'd0, ef});
    endtask

    task automatic load(input logic [2:0] idx, input logic [15:0] v);
        @(negedge clk);
        load_en_i = 1'b1; load_idx_i = idx; load_data_i = v;
        @(negedge clk);
        load_en_i = 1'b0;
        m[idx] = v;
    endtask

    // issue one operation, check result_o in the cycle, update model
    task automatic run(input string req, input logic [2:0] op, input logic [2:0] a,
                       input logic [2:0] b, input logic [2:0] d, input bit ex);
        logic [15:0] exp;
        @(negedge clk);
        op_i = op; src_a_i = a; src_b_i = b; dst_i = d; exec_i = ex;
        exp = ref_op(op, m[a], m[b]);
        #1;
        chk(req, result_o, exp);
        if (ex && op == 3'd7) begin
            ef = (m[a] > m[b]) ? 3'b100 : (m[a] == m[b]) ? 3'b010 : 3'b001;
        end else if (ex) begin
            m[d] = exp;
        end
        @(negedge clk);
        exec_i = 1'b0;
    endtask

    task automatic t_load;
        load(3'd0, 16'h0005); load(3'd1, 16'h1234); load(3'd2, 16'h0F0F);
        load(3'd3, 16'hFFFF); load(3'd4, 16'h0003); load(3'd5, 16'h0000);
        load(3'd6, 16'd200);  load(3'd7, 16'h8000);
        check_bank("R2 load port");
    endtask

    task automatic t_reset;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 8; i++) m[i] = '0;
        ef = 3'b000;
        check_bank("R1 reset clears bank");
        check_flags("R1 reset clears flags");
    endtask

    task automatic t_arith;
        run("R3 add", 3'd0, 3'd1, 3'd2, 3'd0, 1'b1);
        run("R3 add wrap", 3'd0, 3'd3, 3'd4, 3'd5, 1'b1);
        run("R3 sub wrap", 3'd1, 3'd4, 3'd1, 3'd6, 1'b1);
        check_bank("R7 arith writeback");
    endtask

    task automatic t_muldiv;
        run("R4 mul trunc", 3'd2, 3'd3, 3'd4, 3'd5, 1'b1);
        run("R4 div", 3'd3, 3'd1, 3'd4, 3'd6, 1'b1);
        check_bank("R4 muldiv writeback");
    endtask

    task automatic t_div0;
        load(3'd5, 16'h0000);
        run("R8 cmp before div0", 3'd7, 3'd1, 3'd4, 3'd0, 1'b1);
        check_flags("R8 gt set");
        run("R5 div by zero", 3'd3, 3'd1, 3'd5, 3'd2, 1'b1);
        check_flags("R5 flags kept on div0");
        check_bank("R5 div0 writeback");
    endtask

    task automatic t_logic;
        run("R6 and", 3'd4, 3'd1, 3'd3, 3'd2, 1'b1);
        run("R6 or", 3'd5, 3'd4, 3'd7, 3'd6, 1'b1);
        run("R6 not ignores B", 3'd6, 3'd4, 3'd3, 3'd5, 1'b1);
        check_bank("R6 logic writeback");
    endtask

    task automatic t_no_exec;
        run("R7 no exec result", 3'd0, 3'd1, 3'd4, 3'd3, 1'b0);
        check_bank("R7 no exec leaves bank");
    endtask

    task automatic t_compare;
        load(3'd0, 16'h8000); load(3'd1, 16'h0005); load(3'd2, 16'h0005);
        run("R9 cmp result zero", 3'd7, 3'd0, 3'd1, 3'd4, 1'b1);
        check_flags("R8 unsigned gt");
        run("R9 cmp result zero", 3'd7, 3'd1, 3'd2, 3'd4, 1'b1);
        check_flags("R8 eq");
        run("R9 cmp result zero", 3'd7, 3'd1, 3'd0, 3'd4, 1'b1);
        check_flags("R8 unsigned lt");
        check_bank("R9 cmp writes no register");
    endtask

    task automatic t_hold;
        run("R10 add after cmp", 3'd0, 3'd1, 3'd2, 3'd3, 1'b1);
        run("R10 not after cmp", 3'd6, 3'd0, 3'd0, 3'd4, 1'b1);
        check_flags("R10 flags hold");
    endtask

    task automatic t_priority;
        @(negedge clk);
        op_i = 3'd0; src_a_i = 3'd1; src_b_i = 3'd2; dst_i = 3'd2; exec_i = 1'b1;
        load_en_i = 1'b1; load_idx_i = 3'd2; load_data_i = 16'hBEEF;
        @(negedge clk);
        op_i = 3'd0; src_a_i = 3'd1; src_b_i = 3'd1; dst_i = 3'd6; exec_i = 1'b1;
        load_en_i = 1'b1; load_idx_i = 3'd7; load_data_i = 16'h1357;
        @(negedge clk);
        exec_i = 1'b0; load_en_i = 1'b0;
        m[2] = 16'hBEEF; m[7] = 16'h1357;
        check_bank("R11 load owns write port");
    endtask

    task automatic t_self;
        run("R12 dst equals src", 3'd0, 3'd1, 3'd1, 3'd1, 1'b1);
        run("R12 sub self", 3'd1, 3'd2, 3'd1, 3'd2, 1'b1);
        check_bank("R12 self writeback");
    endtask

    initial begin
        for (int i = 0; i < 8; i++) m[i] = '0;
        ef = 3'b000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_load();
        t_reset();
        t_load();
        t_arith();
        t_muldiv();
        t_div0();
        t_logic();
        t_no_exec();
        t_compare();
        t_hold();
        t_priority();
        t_self();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule